// File: doc/BRIEF.md
# Multi-Mode Programmable Timer Bank

This block holds a set of identical timer channels behind a simple register read/write port. Each channel has a control register, a reload-value register and a read-only current-count register. One status register, shared by all channels, shows one pending flag per channel. A channel counts up or down as a 16-bit or 32-bit counter. Its count pulse comes from one of three sources: the system clock, the system clock divided by a power of two from 2 to 64, or rising edges of an external event pin. The count can also be gated by the level of an external pin, or chained to the next-lower channel so that two channels form a wider counter.

At terminal count a channel either stops or reloads from its reload register, and it raises a pending flag. The flag drives the channel's interrupt output when the interrupt is enabled, and software clears it by writing the control register. A debug-halt input can freeze the channels that are set to stop during debug.

Top module: `tmr_bank`

## Requirements
- R1: After reset every control, reload and count register of every channel reads 0, the status register reads 0 and every interrupt output is low.
- R2: Control bit 15 enables the channel; while it is 0 the count keeps its value.
- R3: Control bits 8:6 pick the count pulse: 0 counts every cycle, k = 1..6 gives one step every 2^k cycles, and 7 gives one step per rising edge of the channel's event pin, seen after a two-flop synchronizer.
- R4: Control bits 5:4 pick the mode: 0 counts freely, 1 counts only while the gate pin is low, 2 counts only while the gate pin is high.
- R5: Mode 3 chains the channel: it advances one step in each cycle in which the next-lower channel reaches terminal count; channel 0 never advances in this mode.
- R6: Control bit 2 selects up (0) or down (1) counting; control bit 1 selects a 16-bit (0) or 32-bit (1) counter, and only the selected width counts.
- R7: Terminal count is all ones of the selected width when counting up and 0 when counting down; with control bit 0 clear the count stops there, and reaching it sets the channel's pending flag.
- R8: With control bit 0 set, the step after terminal count loads the reload value, limited to the selected width.
- R9: Writing the reload register also loads the count; the count register is read-only.
- R10: With control bit 10 set, the count freezes while the debug-halt input is high; with it clear, counting continues during debug.
- R11: The interrupt output of a channel is its pending flag AND control bit 3; writing 1 to control bit 9 clears the flag (a terminal count in the same cycle wins); the status register shows the flag of channel n at bit n.
- R12: The address is {channel, select}, with select 0 for control, 1 for reload, 2 for count and 3 for status; a control read returns the stored bits, with bit 9 always reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | CH_IDX_W+2 | Register address {channel, select} |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data for the addressed register |
| evt_i | input | N_CH | External clock/event pin per channel |
| gate_i | input | N_CH | External gate pin per channel |
| dbg_halt_i | input | 1 | Processor debug-halt indication |
| irq_o | output | N_CH | Interrupt output per channel |

## Verification
The assertions take for granted that the write strobe, address and data change only away from the clock edge, and that the debug-halt input is already synchronous to the system clock, while only the event and gate pins may be asynchronous. The bench drives every input at the falling edge. It holds the gate level for several cycles before it enables a channel, and it keeps event pulses at least three cycles high and three low, so that the synchronizer delay never cuts into a counting window.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;

    // Control register layout; software decodes these positions.
    typedef struct packed {
        logic       en;         // 15
        logic [3:0] rsv;        // 14:11
        logic       dbg_stop;   // 10
        logic       irq_clr;    // 9, write-one, never stored
        logic [2:0] clk_sel;    // 8:6
        logic [1:0] mode;       // 5:4
        logic       irq_en;     // 3
        logic       down;       // 2
        logic       wide;       // 1
        logic       reload_en;  // 0
    } tmr_ctrl_t;

    localparam logic [1:0] MODE_FREE    = 2'd0;
    localparam logic [1:0] MODE_GATE_LO = 2'd1;
    localparam logic [1:0] MODE_GATE_HI = 2'd2;
    localparam logic [1:0] MODE_CHAIN   = 2'd3;

    localparam logic [2:0] CLK_EXT = 3'd7;

    localparam logic [1:0] SEL_CTRL   = 2'd0;
    localparam logic [1:0] SEL_RELOAD = 2'd1;
    localparam logic [1:0] SEL_COUNT  = 2'd2;
    localparam logic [1:0] SEL_STATUS = 2'd3;

endpackage

// File: rtl/tmr_prescale.sv
`timescale 1ns/1ps
module tmr_prescale #(
    parameter int DIV_STAGES = 6
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    output logic [DIV_STAGES:0]   tick_o
);
    logic [DIV_STAGES-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign tick_o[0] = 1'b1;
    for (genvar k = 1; k <= DIV_STAGES; k++) begin : g_tick
        assign tick_o[k] = &cnt_q[k-1:0];
    end

    // R3
    slowest_tick_isolated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o[DIV_STAGES] |=> !tick_o[DIV_STAGES]);

endmodule

// File: rtl/tmr_sync.sv
`timescale 1ns/1ps
module tmr_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic lvl_o,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1   = async_i;
        sy_d.s2   = sy_q.s1;
        sy_d.prev = sy_q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sy_q <= '0;
        else         sy_q <= sy_d;
    end

    assign lvl_o  = sy_q.s2;
    assign rise_o = sy_q.s2 & ~sy_q.prev;

endmodule

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter int DIV_STAGES = 6
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  ctrl_wr_i,
    input  logic                  reload_wr_i,
    input  logic [CNT_W-1:0]      wdata_i,
    input  logic [DIV_STAGES:0]   tick_i,
    input  logic                  evt_rise_i,
    input  logic                  gate_lvl_i,
    input  logic                  dbg_halt_i,
    input  logic                  lower_tc_i,
    output tmr_ctrl_t             ctrl_o,
    output logic [CNT_W-1:0]      reload_o,
    output logic [CNT_W-1:0]      count_o,
    output logic                  pend_o,
    output logic                  tc_o,
    output logic                  irq_o
);
    localparam int HALF_W = CNT_W / 2;

    typedef struct packed {
        tmr_ctrl_t         ctrl;
        logic [CNT_W-1:0]  reload;
        logic [CNT_W-1:0]  count;
        logic              pend;
    } ch_state_t;

    ch_state_t st_d, st_q;

    logic [CNT_W-1:0] mask, tc_val, nxt;
    logic             base, adv, step, at_tc, tc_hit;

    always_comb begin
        st_d   = st_q;
        mask   = st_q.ctrl.wide ? {CNT_W{1'b1}} : {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
        tc_val = st_q.ctrl.down ? '0 : mask;
        base   = (st_q.ctrl.clk_sel == CLK_EXT) ? evt_rise_i : tick_i[st_q.ctrl.clk_sel];
        unique case (st_q.ctrl.mode)
            MODE_FREE:    adv = base;
            MODE_GATE_LO: adv = base & ~gate_lvl_i;
            MODE_GATE_HI: adv = base & gate_lvl_i;
            default:      adv = lower_tc_i;
        endcase
        step   = st_q.ctrl.en & ~(st_q.ctrl.dbg_stop & dbg_halt_i) & adv;
        at_tc  = (st_q.count & mask) == tc_val;
        nxt    = (st_q.ctrl.down ? st_q.count - 1'b1 : st_q.count + 1'b1) & mask;
        tc_hit = step & ~at_tc & (nxt == tc_val);

        if (step) begin
            if (!at_tc)                   st_d.count = nxt;
            else if (st_q.ctrl.reload_en) st_d.count = st_q.reload & mask;
        end
        if (tc_hit) st_d.pend = 1'b1;

        if (ctrl_wr_i) begin
            st_d.ctrl         = tmr_ctrl_t'(wdata_i[15:0]);
            st_d.ctrl.rsv     = '0;
            st_d.ctrl.irq_clr = 1'b0;
            if (wdata_i[9] && !tc_hit) st_d.pend = 1'b0;
        end
        if (reload_wr_i) begin
            st_d.reload = wdata_i;
            st_d.count  = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ctrl_o   = st_q.ctrl;
    assign reload_o = st_q.reload;
    assign count_o  = st_q.count;
    assign pend_o   = st_q.pend;
    assign tc_o     = tc_hit;
    assign irq_o    = st_q.pend & st_q.ctrl.irq_en;

    // R2
    hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!st_q.ctrl.en && !reload_wr_i) |=> $stable(count_o));

    // R7
    stop_at_tc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (at_tc && !st_q.ctrl.reload_en && !reload_wr_i) |=> $stable(count_o));

    // R10
    debug_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.ctrl.dbg_stop && dbg_halt_i && !reload_wr_i) |=> $stable(count_o));

    // R11
    pend_on_tc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tc_o |=> pend_o);

    // R2
    no_tc_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !st_q.ctrl.en |-> !tc_o);

endmodule

// File: rtl/tmr_bank.sv
`timescale 1ns/1ps
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int N_CH       = 4,
    parameter int CNT_W      = 32,
    parameter int DIV_STAGES = 6,
    localparam int CH_IDX_W  = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int ADDR_W    = CH_IDX_W + 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 bus_wr_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [CNT_W-1:0]     bus_wdata_i,
    output logic [CNT_W-1:0]     bus_rdata_o,
    input  logic [N_CH-1:0]      evt_i,
    input  logic [N_CH-1:0]      gate_i,
    input  logic                 dbg_halt_i,
    output logic [N_CH-1:0]      irq_o
);
    logic [CH_IDX_W-1:0] ch_idx;
    logic [1:0]          sel;
    logic [DIV_STAGES:0] tick;
    logic [N_CH-1:0]     ctrl_wr, reload_wr, evt_rise, gate_lvl, pend_vec, tc_vec, lower_tc;
    tmr_ctrl_t           ctrl_arr   [N_CH];
    logic [CNT_W-1:0]    reload_arr [N_CH];
    logic [CNT_W-1:0]    count_arr  [N_CH];

    assign ch_idx = bus_addr_i[ADDR_W-1:2];
    assign sel    = bus_addr_i[1:0];

    tmr_prescale #(.DIV_STAGES(DIV_STAGES)) u_pre (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .tick_o(tick)
    );

    assign lower_tc[0] = 1'b0;

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        if (g > 0) begin : g_chain
            assign lower_tc[g] = tc_vec[g-1];
        end

        assign ctrl_wr[g]   = bus_wr_i && (sel == SEL_CTRL)   && (int'(ch_idx) == g);
        assign reload_wr[g] = bus_wr_i && (sel == SEL_RELOAD) && (int'(ch_idx) == g);

        tmr_sync u_evt (
            .clk_i (clk_i), .rst_ni(rst_ni), .async_i(evt_i[g]),
            .lvl_o (), .rise_o(evt_rise[g])
        );
        tmr_sync u_gate (
            .clk_i (clk_i), .rst_ni(rst_ni), .async_i(gate_i[g]),
            .lvl_o (gate_lvl[g]), .rise_o()
        );

        tmr_channel #(.CNT_W(CNT_W), .DIV_STAGES(DIV_STAGES)) u_ch (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .ctrl_wr_i  (ctrl_wr[g]),
            .reload_wr_i(reload_wr[g]),
            .wdata_i    (bus_wdata_i),
            .tick_i     (tick),
            .evt_rise_i (evt_rise[g]),
            .gate_lvl_i (gate_lvl[g]),
            .dbg_halt_i (dbg_halt_i),
            .lower_tc_i (lower_tc[g]),
            .ctrl_o     (ctrl_arr[g]),
            .reload_o   (reload_arr[g]),
            .count_o    (count_arr[g]),
            .pend_o     (pend_vec[g]),
            .tc_o       (tc_vec[g]),
            .irq_o      (irq_o[g])
        );
    end

    always_comb begin
        bus_rdata_o = '0;
        if (sel == SEL_STATUS) begin
            bus_rdata_o = CNT_W'(pend_vec);
        end else if (int'(ch_idx) < N_CH) begin
            unique case (sel)
                SEL_CTRL:   bus_rdata_o = CNT_W'(ctrl_arr[ch_idx]);
                SEL_RELOAD: bus_rdata_o = reload_arr[ch_idx];
                default:    bus_rdata_o = count_arr[ch_idx];
            endcase
        end
    end

    // R12
    single_write_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({ctrl_wr, reload_wr}));

endmodule

// File: tb/tmr_bank_tb_top.sv
`timescale 1ns/1ps
module tmr_bank_tb_top;
    localparam int N = 4;
    localparam logic [31:0] EN = 32'h8000;

    logic        clk = 1'b0, rst_n = 1'b0, wr = 1'b0, halt = 1'b0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    wire  [31:0] rdata;
    logic [N-1:0] evt = '0, gate = '0;
    wire  [N-1:0] irq;
    int vecs = 0, errs = 0;

    always #2 clk = ~clk;

    tmr_bank #(.N_CH(N), .CNT_W(32), .DIV_STAGES(6)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .evt_i(evt), .gate_i(gate),
        .dbg_halt_i(halt), .irq_o(irq)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        vecs++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr_reg(int ch, int s, logic [31:0] d);
        @(negedge clk);
        wr = 1'b1; addr = 4'(ch * 4 + s); wdata = d;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic rd_reg(int ch, int s, output logic [31:0] d);
        @(negedge clk);
        addr = 4'(ch * 4 + s);
        #1 d = rdata;
    endtask

    function automatic logic [31:0] mk(bit dbg, logic [2:0] cs, logic [1:0] md,
                                       bit ie, bit dn, bit wd, bit rl);
        return {16'h0, 1'b0, 4'h0, dbg, 1'b0, cs, md, ie, dn, wd, rl};
    endfunction

    // enable for exactly k count edges, then disable with the same fields
    task automatic run(int ch, logic [31:0] c, int k);
        wr_reg(ch, 0, c | EN);
        repeat (k - 1) @(posedge clk);
        wr_reg(ch, 0, c);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        for (int ch = 0; ch < N; ch++) begin
            for (int s = 0; s < 3; s++) begin
                rd_reg(ch, s, d);
                check("R1 register after reset", d, 32'h0);
            end
        end
        rd_reg(0, 3, d);
        check("R1 status after reset", d, 32'h0);
        check("R1 irq after reset", {28'h0, irq}, 32'h0);
    endtask

    task automatic t_readback;
        logic [31:0] d;
        wr_reg(2, 0, 32'hFFFF_07FF);
        rd_reg(2, 0, d);
        check("R12 ctrl readback, bit 9 reads 0", d, 32'h0000_05FF);
        rd_reg(3, 0, d);
        check("R12 neighbour ctrl untouched", d, 32'h0);
        wr_reg(2, 0, 32'h0);
        wr_reg(2, 2, 32'h1234);
        rd_reg(2, 2, d);
        check("R9 count register read-only", d, 32'h0);
    endtask

    task automatic t_up_hold;
        logic [31:0] d;
        wr_reg(0, 1, 32'd5);
        rd_reg(0, 2, d);
        check("R9 reload write loads count", d, 32'd5);
        run(0, mk(0, 3'd0, 2'd0, 0, 0, 0, 0), 10);
        rd_reg(0, 2, d);
        check("R6 up count at system clock", d, 32'd15);
        repeat (10) @(posedge clk);
        rd_reg(0, 2, d);
        check("R2 disabled channel holds", d, 32'd15);
    endtask

    task automatic t_down;
        logic [31:0] d;
        wr_reg(0, 1, 32'd20);
        run(0, mk(0, 3'd0, 2'd0, 0, 1, 0, 0), 7);
        rd_reg(0, 2, d);
        check("R6 down count", d, 32'd13);
    endtask

    task automatic t_prescale;
        logic [31:0] d;
        wr_reg(0, 1, 32'd0);
        run(0, mk(0, 3'd3, 2'd0, 0, 0, 0, 0), 64);
        rd_reg(0, 2, d);
        check("R3 divide by 8", d, 32'd8);
        wr_reg(0, 1, 32'd0);
        run(0, mk(0, 3'd6, 2'd0, 0, 0, 0, 0), 128);
        rd_reg(0, 2, d);
        check("R3 divide by 64", d, 32'd2);
    endtask

    task automatic t_tc_stop;
        logic [31:0] d;
        wr_reg(0, 0, 32'h200);
        wr_reg(0, 1, 32'h0000_FFF0);
        run(0, mk(0, 3'd0, 2'd0, 0, 0, 0, 0), 40);
        rd_reg(0, 2, d);
        check("R7 16-bit up stops at FFFF", d, 32'h0000_FFFF);
        rd_reg(0, 3, d);
        check("R11 status shows channel 0 pending", d, 32'h1);
        check("R11 irq masked while bit 3 clear", {31'h0, irq[0]}, 32'h0);
        wr_reg(0, 0, mk(0, 3'd0, 2'd0, 1, 0, 0, 0));
        check("R11 irq raised when bit 3 set", {31'h0, irq[0]}, 32'h1);
        wr_reg(0, 0, mk(0, 3'd0, 2'd0, 1, 0, 0, 0) | 32'h200);
        check("R11 irq dropped after clear", {31'h0, irq[0]}, 32'h0);
        rd_reg(0, 3, d);
        check("R11 status cleared", d, 32'h0);
    endtask

    task automatic t_reload;
        logic [31:0] d;
        wr_reg(0, 1, 32'h0000_FFFC);
        run(0, mk(0, 3'd0, 2'd0, 0, 0, 0, 1), 6);
        rd_reg(0, 2, d);
        check("R8 reload after terminal count", d, 32'h0000_FFFE);
        rd_reg(0, 3, d);
        check("R7 pending on reaching terminal count", d, 32'h1);
        wr_reg(0, 0, 32'h200);
    endtask

    task automatic t_wide;
        logic [31:0] d;
        wr_reg(0, 1, 32'h0000_FFFE);
        run(0, mk(0, 3'd0, 2'd0, 0, 0, 1, 0), 4);
        rd_reg(0, 2, d);
        check("R6 32-bit count passes 16-bit boundary", d, 32'h0001_0002);
    endtask

    task automatic t_down_tc;
        logic [31:0] d;
        wr_reg(0, 0, 32'h200);
        wr_reg(0, 1, 32'd3);
        run(0, mk(0, 3'd0, 2'd0, 0, 1, 0, 0), 10);
        rd_reg(0, 2, d);
        check("R7 down count stops at zero", d, 32'd0);
        rd_reg(0, 3, d);
        check("R7 pending on zero", d, 32'h1);
        wr_reg(0, 0, 32'h200);
    endtask

    task automatic t_gate;
        logic [31:0] d;
        @(negedge clk); gate[0] = 1'b1;
        repeat (5) @(posedge clk);
        wr_reg(0, 1, 32'd100);
        run(0, mk(0, 3'd0, 2'd1, 0, 0, 0, 0), 20);
        rd_reg(0, 2, d);
        check("R4 low-gated mode blocked by high gate", d, 32'd100);
        run(0, mk(0, 3'd0, 2'd2, 0, 0, 0, 0), 20);
        rd_reg(0, 2, d);
        check("R4 high-gated mode counts with high gate", d, 32'd120);
        @(negedge clk); gate[0] = 1'b0;
    endtask

    task automatic t_ext;
        logic [31:0] d;
        wr_reg(0, 1, 32'd0);
        wr_reg(0, 0, mk(0, 3'd7, 2'd0, 0, 0, 0, 0) | EN);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); evt[0] = 1'b1;
            repeat (3) @(posedge clk);
            @(negedge clk); evt[0] = 1'b0;
            repeat (3) @(posedge clk);
        end
        repeat (6) @(posedge clk);
        wr_reg(0, 0, 32'h0);
        rd_reg(0, 2, d);
        check("R3 external event edges counted", d, 32'd5);
    endtask

    task automatic t_chain;
        logic [31:0] d;
        wr_reg(1, 1, 32'd0);
        wr_reg(1, 0, mk(0, 3'd0, 2'd3, 0, 0, 0, 0) | EN);
        wr_reg(0, 1, 32'h0000_FFFE);
        run(0, mk(0, 3'd0, 2'd0, 0, 0, 0, 1), 10);
        wr_reg(1, 0, 32'h0);
        rd_reg(1, 2, d);
        check("R5 chained channel counts lower terminal counts", d, 32'd5);
        rd_reg(0, 2, d);
        check("R8 lower channel reload cycle", d, 32'h0000_FFFE);
        wr_reg(0, 0, 32'h200);
        wr_reg(1, 0, 32'h200);
        wr_reg(0, 1, 32'd7);
        run(0, mk(0, 3'd0, 2'd3, 0, 0, 0, 0), 10);
        rd_reg(0, 2, d);
        check("R5 channel 0 never advances when chained", d, 32'd7);
    endtask

    task automatic t_debug;
        logic [31:0] d;
        @(negedge clk); halt = 1'b1;
        wr_reg(0, 1, 32'd50);
        run(0, mk(1, 3'd0, 2'd0, 0, 0, 0, 0), 10);
        rd_reg(0, 2, d);
        check("R10 frozen during debug halt", d, 32'd50);
        run(0, mk(0, 3'd0, 2'd0, 0, 0, 0, 0), 10);
        rd_reg(0, 2, d);
        check("R10 counts through halt when bit 10 clear", d, 32'd60);
        @(negedge clk); halt = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_readback();
        t_up_hold();
        t_down();
        t_prescale();
        t_tc_stop();
        t_reload();
        t_wide();
        t_down_tc();
        t_gate();
        t_ext();
        t_chain();
        t_debug();
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule